// File: doc/BRIEF.md
# Single-Cycle Cycle-Stealing Transfer Interface

This block is the device side of a single-cycle direct memory transfer link. The device keeps its own 12-bit memory address register and a 12-bit data buffer. It also keeps a direction flag and a request flip-flop, and it drives all of them to the host. Software loads the address and the direction through a write port before a block starts. The device then raises its request. The host answers with a one-cycle acknowledge pulse at the start of the stolen cycle. That pulse clears the request, unless the device asks for back-to-back cycles, and it advances the address by one.

A single buffer is used for both directions. For input transfers the device fills it, and it is driven to the host. For output transfers it captures the host memory-buffer word under a strobe that the device makes itself. The break-active level together with the late timing pulse arms a one-shot enable. The early timing pulse of the next host cycle consumes that enable and latches the word. The cycle-select output is a fixed level chosen by a parameter.

Top module: `dbrk_if`

## Requirements
- R1: After reset, brk_req_o, addr_o, data_o, dir_o and strobe_o are all 0.
- R2: When brk_req_o is 0, a cycle with cfg_we_i=1 loads cfg_addr_i into addr_o and cfg_dir_i into dir_o by the next cycle. When brk_req_o is 1, cfg_we_i has no effect. If cfg_we_i and addr_ack_i fall in the same cycle with no request pending, the load wins.
- R3: A cycle with req_set_i=1 makes brk_req_o 1 in the next cycle.
- R4: A cycle with addr_ack_i=1 (and no load) makes addr_o one higher in the next cycle, wrapping from 4095 to 0. brk_req_o then drops to 0 unless burst_i or req_set_i is 1 in that same cycle.
- R5: dev_we_i loads dev_data_i into data_o by the next cycle only when dir_o=1 (input, device to host) and brk_req_o=0. Otherwise it has no effect.
- R6: A cycle with ts_late_i=1 and brk_act_i=1 arms the capture enable. A later cycle with ts_early_i=1 while the enable is armed and dir_o=0 (output, host to device) puts host_mb_i on data_o in the next cycle. strobe_o is 1 for exactly that one cycle.
- R7: ts_early_i has no effect on data_o or strobe_o in these cases: the enable is not armed, ts_late_i came without brk_act_i, or dir_o=1.
- R8: ts_early_i consumes the enable, so a second ts_early_i with no new arming captures nothing. If arming and consuming fall in the same cycle, the enable stays armed for the next ts_early_i.
- R9: cycle_sel_o always equals the parameter SINGLE_CYC (default 1, meaning single-cycle breaks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Programmed write of address and direction |
| cfg_addr_i | input | 12 | Starting address to load |
| cfg_dir_i | input | 1 | Direction to load (1 input, 0 output) |
| dev_we_i | input | 1 | Device writes the buffer for an input transfer |
| dev_data_i | input | 12 | Device word for an input transfer |
| req_set_i | input | 1 | Raise the transfer request |
| burst_i | input | 1 | Keep the request across the acknowledge |
| addr_ack_i | input | 1 | Host address-accepted pulse |
| brk_act_i | input | 1 | Host is in the stolen cycle |
| ts_early_i | input | 1 | Early timing pulse of a host cycle |
| ts_late_i | input | 1 | Late timing pulse of a host cycle |
| host_mb_i | input | 12 | Host memory-buffer word |
| addr_o | output | 12 | Transfer address to host |
| data_o | output | 12 | Shared data buffer |
| dir_o | output | 1 | Transfer direction |
| cycle_sel_o | output | 1 | Fixed cycle-select level |
| brk_req_o | output | 1 | Transfer request |
| strobe_o | output | 1 | One-cycle pulse after an output capture |

## Verification
Two pairs of events can fall in one cycle, and the bench drives both on purpose.

The first pair is the acknowledge and a fresh request. The bench drives addr_ack_i and req_set_i in one cycle. It expects the address to advance and the request to stay up, and it contrasts this with an acknowledge alone, which must drop the request.

The second pair is arming and consuming the capture enable. The bench fires ts_late_i with brk_act_i in the same cycle as ts_early_i. The first word must be captured, and a following ts_early_i on its own must still capture a second word.

// File: rtl/dbrk_pkg.sv
package dbrk_pkg;
  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } dir_e;
endpackage

// File: rtl/dbrk_addr_reg.sv
module dbrk_addr_reg #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (load_i)  addr_o <= load_val_i;
    else if (adv_i)   addr_o <= addr_o + ONE;
  end
endmodule

// File: rtl/dbrk_req_ctrl.sv
module dbrk_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic hold_i,
  output logic req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    req_o <= 1'b0;
    else if (set_i) req_o <= 1'b1;   // new request beats a clear
    else if (ack_i && !hold_i) req_o <= 1'b0;
  end
endmodule

// File: rtl/dbrk_xfer_buf.sv
module dbrk_xfer_buf
  import dbrk_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  dir_e          dir_i,
  input  logic          lock_i,
  input  logic          dev_we_i,
  input  logic [DW-1:0] dev_data_i,
  input  logic          brk_act_i,
  input  logic          ts_early_i,
  input  logic          ts_late_i,
  input  logic [DW-1:0] host_mb_i,
  output logic [DW-1:0] data_o,
  output logic          strobe_o
);
  logic brk_en_q;
  logic arm, cap, dev_ld;

  assign arm    = ts_late_i && brk_act_i;
  assign cap    = ts_early_i && brk_en_q && (dir_i == DIR_OUT);
  assign dev_ld = dev_we_i && !lock_i && (dir_i == DIR_IN);

  // one-shot enable; arming wins over consumption
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         brk_en_q <= 1'b0;
    else if (arm)        brk_en_q <= 1'b1;
    else if (ts_early_i) brk_en_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= cap;
      if (cap)         data_o <= host_mb_i;
      else if (dev_ld) data_o <= dev_data_i;
    end
  end
endmodule

// File: rtl/dbrk_if.sv
module dbrk_if
  import dbrk_pkg::*;
#(
  parameter int       AW         = 12,
  parameter int       DW         = 12,
  parameter bit       SINGLE_CYC = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_addr_i,
  input  logic          cfg_dir_i,
  input  logic          dev_we_i,
  input  logic [DW-1:0] dev_data_i,
  input  logic          req_set_i,
  input  logic          burst_i,
  input  logic          addr_ack_i,
  input  logic          brk_act_i,
  input  logic          ts_early_i,
  input  logic          ts_late_i,
  input  logic [DW-1:0] host_mb_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          dir_o,
  output logic          cycle_sel_o,
  output logic          brk_req_o,
  output logic          strobe_o
);
  dir_e dir_q;
  logic cfg_ld;

  // programmed setup is frozen while a request is outstanding
  assign cfg_ld = cfg_we_i && !brk_req_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= DIR_OUT;
    else if (cfg_ld) dir_q <= dir_e'(cfg_dir_i);
  end

  assign dir_o       = dir_q;
  assign cycle_sel_o = SINGLE_CYC;

  dbrk_addr_reg #(.AW(AW)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_ld),
    .load_val_i (cfg_addr_i),
    .adv_i      (addr_ack_i),
    .addr_o     (addr_o)
  );

  dbrk_req_ctrl u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_set_i),
    .ack_i  (addr_ack_i),
    .hold_i (burst_i),
    .req_o  (brk_req_o)
  );

  dbrk_xfer_buf #(.DW(DW)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_i      (dir_q),
    .lock_i     (brk_req_o),
    .dev_we_i   (dev_we_i),
    .dev_data_i (dev_data_i),
    .brk_act_i  (brk_act_i),
    .ts_early_i (ts_early_i),
    .ts_late_i  (ts_late_i),
    .host_mb_i  (host_mb_i),
    .data_o     (data_o),
    .strobe_o   (strobe_o)
  );
endmodule

// File: rtl/dbrk_chk.sv
module dbrk_chk #(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic          dev_we_i,
  input logic          req_set_i,
  input logic          burst_i,
  input logic          addr_ack_i,
  input logic          ts_early_i,
  input logic [AW-1:0] addr_o,
  input logic [DW-1:0] data_o,
  input logic          dir_o,
  input logic          brk_req_o,
  input logic          strobe_o
);
  // R3
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_set_i |=> brk_req_o);

  // R4
  req_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ack_i && !req_set_i && !burst_i) |=> !brk_req_o);

  // R4
  addr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_ack_i && !(cfg_we_i && !brk_req_o)) |=> (addr_o == $past(addr_o) + 1'b1));

  // R2
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_req_o && !addr_ack_i) |=> ($stable(addr_o) && $stable(dir_o)));

  // R6
  strobe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_early_i && !cfg_we_i) |=> !strobe_o);

  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ts_early_i && !dev_we_i) |=> $stable(data_o));
endmodule

bind dbrk_if dbrk_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_we_i   (cfg_we_i),
  .dev_we_i   (dev_we_i),
  .req_set_i  (req_set_i),
  .burst_i    (burst_i),
  .addr_ack_i (addr_ack_i),
  .ts_early_i (ts_early_i),
  .addr_o     (addr_o),
  .data_o     (data_o),
  .dir_o      (dir_o),
  .brk_req_o  (brk_req_o),
  .strobe_o   (strobe_o)
);

// File: tb/sim_dbrk_if.sv
`timescale 1ns/1ps
module sim_dbrk_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 0, cfg_dir = 0, dev_we = 0, req_set = 0, burst = 0;
  logic        ack = 0, act = 0, ts_e = 0, ts_l = 0;
  logic [11:0] cfg_addr = '0, dev_data = '0, mb = '0;
  logic [11:0] addr, data;
  logic        dir, csel, req, stb;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dbrk_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_dir_i(cfg_dir), .dev_we_i(dev_we), .dev_data_i(dev_data),
    .req_set_i(req_set), .burst_i(burst), .addr_ack_i(ack), .brk_act_i(act),
    .ts_early_i(ts_e), .ts_late_i(ts_l), .host_mb_i(mb),
    .addr_o(addr), .data_o(data), .dir_o(dir), .cycle_sel_o(csel),
    .brk_req_o(req), .strobe_o(stb)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cfg_we = 0; dev_we = 0; req_set = 0; burst = 0; ack = 0;
    act = 0; ts_e = 0; ts_l = 0;
  endtask

  task automatic chk(string tag, logic [31:0] act_v, logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic cfg(logic [11:0] a, logic d);
    idle(); cfg_we = 1; cfg_addr = a; cfg_dir = d; tick(); idle();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    #23 rst_n = 1; #1;
    chk("R1 req", req, 0); chk("R1 addr", addr, 0); chk("R1 data", data, 0);
    chk("R1 dir", dir, 0); chk("R1 strobe", stb, 0);
    chk("R9 csel", csel, 1);

    // R2 / R3 / R4 address and request sweep
    for (int i = 0; i < 64; i++) begin
      logic [11:0] a;
      a = (i == 63) ? 12'hFFF : 12'((i * 131) % 4096);
      cfg(a, 0);
      chk("R2 load", addr, a);
      req_set = 1; tick(); idle();
      chk("R3 req", req, 1);
      cfg_we = 1; cfg_addr = ~a; cfg_dir = 1; tick(); idle();
      chk("R2 frozen addr", addr, a);
      chk("R2 frozen dir", dir, 0);
      ack = 1; tick(); idle();
      chk("R4 adv", addr, 12'(a + 1));
      chk("R4 clear", req, 0);
      chk("R9 csel", csel, 1);
    end

    // R4 burst hold, then release
    cfg(12'h100, 0);
    req_set = 1; tick(); idle();
    ack = 1; burst = 1; tick(); idle();
    chk("R4 burst req", req, 1); chk("R4 burst addr", addr, 12'h101);
    ack = 1; tick(); idle();
    chk("R4 release req", req, 0); chk("R4 release addr", addr, 12'h102);
    // R4 ack and new request together
    req_set = 1; tick(); idle();
    ack = 1; req_set = 1; tick(); idle();
    chk("R4 ack+set req", req, 1); chk("R4 ack+set addr", addr, 12'h103);
    ack = 1; tick(); idle();
    chk("R4 drop", req, 0);
    // R2 load beats stray ack
    cfg_we = 1; cfg_addr = 12'h555; cfg_dir = 0; ack = 1; tick(); idle();
    chk("R2 load wins", addr, 12'h555);

    // R5 device load
    cfg(12'h0, 1);
    dev_we = 1; dev_data = 12'hA5A; tick(); idle();
    chk("R5 in load", data, 12'hA5A);
    req_set = 1; tick(); idle();
    dev_we = 1; dev_data = 12'h111; tick(); idle();
    chk("R5 locked", data, 12'hA5A);
    ack = 1; tick(); idle();
    // R7 dir input blocks capture
    ts_l = 1; act = 1; tick(); idle();
    ts_e = 1; mb = 12'h3C3; tick(); idle();
    chk("R7 dir in data", data, 12'hA5A); chk("R7 dir in stb", stb, 0);
    cfg(12'h0, 0);
    dev_we = 1; dev_data = 12'h222; tick(); idle();
    chk("R5 out ignored", data, 12'hA5A);

    // R6 / R8 capture sweep
    for (int i = 0; i < 64; i++) begin
      logic [11:0] v;
      v = 12'((i * 67 + 5) % 4096);
      ts_l = 1; act = 1; tick(); idle();
      chk("R6 no early stb", stb, 0);
      ts_e = 1; mb = v; tick(); idle();
      chk("R6 capture", data, v); chk("R6 strobe", stb, 1);
      tick();
      chk("R6 strobe one", stb, 0);
      ts_e = 1; mb = ~v; tick(); idle();
      chk("R8 consumed data", data, v); chk("R8 consumed stb", stb, 0);
    end

    // R7 late pulse without break-active
    ts_l = 1; tick(); idle();
    ts_e = 1; mb = 12'h0F0; tick(); idle();
    chk("R7 no act stb", stb, 0);

    // R8 arm and consume in one cycle
    ts_l = 1; act = 1; tick(); idle();
    ts_e = 1; ts_l = 1; act = 1; mb = 12'h123; tick(); idle();
    chk("R8 both cap", data, 12'h123);
    ts_e = 1; mb = 12'h456; tick(); idle();
    chk("R8 rearmed cap", data, 12'h456); chk("R8 rearmed stb", stb, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule